// File: doc/BRIEF.md
# Serial EEPROM Config Loader

This block fills in an adapter's basic configuration from a serial EEPROM once it is told to start. It first releases the core from reset through its `core_en` output. It then asks an external byte-read engine for eight bytes, one request at a time. The bytes are the ring-speed byte, the RAM-size byte and the six station-address bytes. It keeps the decoded results on its outputs and raises `cfg_valid` when every read has come back.

The engine is reached through a small request/response port. `rd_req` is a one-cycle pulse that carries `rd_addr`. The engine later answers with a one-cycle `rd_done` that carries `rd_data`. A failed engine read returns 0xFF. The loader stores that value unchanged, the same way as any other byte.

The controller is a five-state machine:
- ST_IDLE moves to ST_ENABLE on `start`.
- ST_ENABLE moves to ST_ISSUE unconditionally.
- ST_ISSUE moves to ST_WAIT unconditionally.
- ST_WAIT returns to ST_ISSUE on `rd_done` when bytes remain, and moves to ST_DONE on the `rd_done` of the last byte.
- ST_DONE moves to ST_ENABLE on `start`, which reloads everything.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: On `start` in idle, `core_en` is 1 in the next cycle and stays 1. No `rd_req` occurs while `core_en` is 0, and none occurs in the first cycle that `core_en` is 1.
- R2: Requests use these addresses, in this order: the speed offset, the RAM offset, then address base+0 up to base+5.
- R3: `rd_req` lasts one cycle. No new `rd_req` is issued until the previous one has received its `rd_done`.
- R4: `speed_sel` is 1 when the speed byte is nonzero (4 Mbps) and 0 when the speed byte is zero (16 Mbps).
- R5: `ram_kb` equals the RAM-size byte multiplied by 128, as a 16-bit value.
- R6: The station address byte read from base+0 sits at `station_addr[47:40]`, and so on in turn, down to the byte from base+5 at `[7:0]`.
- R7: A failed read, which returns 0xFF, is used as-is. A failed speed read gives `speed_sel`=1. A failed RAM read gives `ram_kb`=32640. A failed address read gives an 0xFF byte.
- R8: `cfg_valid` is 1 from the cycle after the eighth `rd_done` until the next accepted `start`, and it is 0 one cycle after that `start`. A `start` during loading is ignored.
- R9: An `rd_done` that arrives while no request is outstanding changes no output.
- R10: After reset, `core_en`, `rd_req`, `cfg_valid`, `speed_sel`, `ram_kb` and `station_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or repeat) a load |
| core_en | output | 1 | Core reset released |
| rd_req | output | 1 | Byte read request pulse |
| rd_addr | output | 8 | EEPROM offset of the request |
| rd_done | input | 1 | Engine response pulse |
| rd_data | input | 8 | Byte returned with rd_done |
| speed_sel | output | 1 | 1 = 4 Mbps, 0 = 16 Mbps |
| ram_kb | output | 16 | On-board RAM size in KB |
| station_addr | output | 48 | Station address, first byte in the top bits |
| cfg_valid | output | 1 | All configuration bytes loaded |

## Verification
The hardest cases to reach from the ports are the ones where a response arrives at the wrong moment. One is a stray `rd_done` that arrives while nothing is outstanding. Another is a `start` that arrives in the middle of a load.

The bench's engine model answers with a random latency and can fail any chosen read. Directed steps add the stray case: they inject `rd_done` carrying an unrelated byte, both just after reset and after `cfg_valid` has risen. They also re-pulse `start` while reads are pending. The bench then confirms that the outputs and the address order did not change.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENABLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } ld_state_t;
endpackage

// File: rtl/cfgld_fsm.sv
module cfgld_fsm #(
    parameter int NREAD = 8,
    localparam int IW = $clog2(NREAD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd_done,
    output logic          core_en,
    output logic          rd_req,
    output logic          wr_en,
    output logic          cfg_valid,
    output logic [IW-1:0] idx
);
    import cfgld_pkg::*;

    ld_state_t state, nxt;
    logic      last;

    assign last = (idx == IW'(NREAD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  idx <= '0;
        else if (state == ST_ENABLE)                 idx <= '0;
        else if (state == ST_WAIT && rd_done && !last) idx <= idx + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_ENABLE;
            ST_ENABLE: nxt = ST_ISSUE;
            ST_ISSUE:  nxt = ST_WAIT;
            ST_WAIT:   if (rd_done) nxt = last ? ST_DONE : ST_ISSUE;
            ST_DONE:   if (start) nxt = ST_ENABLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        core_en   = (state != ST_IDLE);
        rd_req    = (state == ST_ISSUE);
        wr_en     = (state == ST_WAIT) && rd_done;
        cfg_valid = (state == ST_DONE);
    end
endmodule

// File: rtl/cfgld_addr_map.sv
module cfgld_addr_map #(
    parameter int          NREAD   = 8,
    parameter int          AW      = 8,
    parameter logic [7:0]  SPD_OFS = 8'h21,
    parameter logic [7:0]  RAM_OFS = 8'h22,
    parameter logic [7:0]  MAC_OFS = 8'h30,
    localparam int         IW      = $clog2(NREAD)
) (
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] step;

    assign step = AW'(idx) - AW'(2);

    always_comb begin
        if (idx == IW'(0))      addr = AW'(SPD_OFS);
        else if (idx == IW'(1)) addr = AW'(RAM_OFS);
        else                    addr = AW'(MAC_OFS) + step;
    end
endmodule

// File: rtl/cfgld_store.sv
module cfgld_store #(
    parameter int NMAC  = 6,
    parameter int DW    = 8,
    parameter int RAMW  = 16,
    parameter int SCALE = 7,
    localparam int NREAD = NMAC + 2,
    localparam int IW    = $clog2(NREAD)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      idx,
    input  logic [DW-1:0]      data,
    output logic               speed_sel,
    output logic [RAMW-1:0]    ram_kb,
    output logic [NMAC*DW-1:0] station_addr
);
    logic [DW-1:0] spd_q, ram_q;
    logic [DW-1:0] mac_q [NMAC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spd_q <= '0;
            ram_q <= '0;
        end else if (wr_en) begin
            if (idx == IW'(0)) spd_q <= data;
            if (idx == IW'(1)) ram_q <= data;
        end
    end

    for (genvar g = 0; g < NMAC; g++) begin : g_mac
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mac_q[g] <= '0;
            else if (wr_en && idx == IW'(g + 2)) mac_q[g] <= data;
        end
        assign station_addr[(NMAC-1-g)*DW +: DW] = mac_q[g];
    end

    assign speed_sel = |spd_q;
    assign ram_kb    = RAMW'(ram_q) << SCALE;
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
    parameter logic [7:0] SPD_OFS = 8'h21,
    parameter logic [7:0] RAM_OFS = 8'h22,
    parameter logic [7:0] MAC_OFS = 8'h30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        core_en,
    output logic        rd_req,
    output logic [7:0]  rd_addr,
    input  logic        rd_done,
    input  logic [7:0]  rd_data,
    output logic        speed_sel,
    output logic [15:0] ram_kb,
    output logic [47:0] station_addr,
    output logic        cfg_valid
);
    localparam int NMAC  = 6;
    localparam int NREAD = NMAC + 2;
    localparam int IW    = $clog2(NREAD);

    logic          wr_en;
    logic [IW-1:0] idx;

    cfgld_fsm #(.NREAD(NREAD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_done(rd_done),
        .core_en(core_en), .rd_req(rd_req), .wr_en(wr_en),
        .cfg_valid(cfg_valid), .idx(idx)
    );

    cfgld_addr_map #(
        .NREAD(NREAD), .AW(8), .SPD_OFS(SPD_OFS),
        .RAM_OFS(RAM_OFS), .MAC_OFS(MAC_OFS)
    ) u_map (
        .idx(idx), .addr(rd_addr)
    );

    cfgld_store #(.NMAC(NMAC), .DW(8), .RAMW(16), .SCALE(7)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .data(rd_data),
        .speed_sel(speed_sel), .ram_kb(ram_kb), .station_addr(station_addr)
    );
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        core_en,
    input logic        rd_req,
    input logic        rd_done,
    input logic        cfg_valid,
    input logic [15:0] ram_kb
);
    logic pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend <= 1'b0;
        else if (rd_req)  pend <= 1'b1;
        else if (rd_done) pend <= 1'b0;
    end

    // R1
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> core_en);

    // R1
    en_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |-> !rd_req);

    // R3
    one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !pend);

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R8
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> !rd_req && !pend);

    // R5
    ram_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ram_kb[6:0] == 7'd0);
endmodule

bind eeprom_cfg_loader cfgld_chk u_chk (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .rd_req(rd_req),
    .rd_done(rd_done), .cfg_valid(cfg_valid), .ram_kb(ram_kb)
);

// File: tb/eeprom_cfg_loader_test.sv
module eeprom_cfg_loader_test;
    localparam logic [7:0] SPD = 8'h21;
    localparam logic [7:0] RAMO = 8'h22;
    localparam logic [7:0] MACO = 8'h30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic core_en, rd_req, rd_done, speed_sel, cfg_valid;
    logic [7:0]  rd_addr, rd_data;
    logic [15:0] ram_kb;
    logic [47:0] station_addr;

    logic       mdl_done = 1'b0, inj_done = 1'b0;
    logic [7:0] mdl_data = 8'h00, inj_data = 8'h00;

    assign rd_done = mdl_done | inj_done;
    assign rd_data = inj_done ? inj_data : mdl_data;

    always #2.5 clk = ~clk;

    eeprom_cfg_loader #(.SPD_OFS(SPD), .RAM_OFS(RAMO), .MAC_OFS(MACO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .core_en(core_en),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
        .speed_sel(speed_sel), .ram_kb(ram_kb), .station_addr(station_addr),
        .cfg_valid(cfg_valid)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem [8];
    logic       fmask [8];
    int         latmax = 0;

    int  nreq = 0, ndone = 0, lat = 0;
    logic pend = 1'b0;

    function automatic logic [7:0] exp_addr(int k);
        if (k == 0) return SPD;
        if (k == 1) return RAMO;
        return MACO + 8'(k - 2);
    endfunction

    function automatic logic [7:0] eff(int k);
        return fmask[k] ? 8'hFF : mem[k];
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // engine model
    always @(negedge clk) begin
        mdl_done = 1'b0;
        if (pend) begin
            if (lat == 0) begin
                mdl_done = 1'b1;
                mdl_data = eff(ndone % 8);
                pend = 1'b0;
                ndone++;
            end else lat--;
        end
        if (rd_req && rst_n) begin
            chk("R3 no overlap", {63'd0, pend}, 64'd0);
            chk("R1 enabled", {63'd0, core_en}, 64'd1);
            chk("R2 order", {56'd0, rd_addr}, {56'd0, exp_addr(nreq % 8)});
            pend = 1'b1;
            lat  = int'($urandom % 32'(latmax + 1));
            nreq++;
        end
    end

    task automatic check_outs(string tag);
        logic [47:0] m;
        m = {eff(2), eff(3), eff(4), eff(5), eff(6), eff(7)};
        chk({tag, " R4 R7 speed"}, {63'd0, speed_sel}, {63'd0, eff(0) != 8'd0});
        chk({tag, " R5 R7 ram"}, {48'd0, ram_kb}, {48'd0, 16'(eff(1)) * 16'd128});
        chk({tag, " R6 R7 addr"}, {16'd0, station_addr}, {16'd0, m});
    endtask

    task automatic run_cfg(int lm, bit mid_start);
        int base;
        base = ndone;
        latmax = lm;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R1 core_en rise", {63'd0, core_en}, 64'd1);
        chk("R1 no early req", {63'd0, rd_req}, 64'd0);
        chk("R8 valid drops", {63'd0, cfg_valid}, 64'd0);
        if (mid_start) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        wait (ndone == base + 8);
        chk("R8 not early", {63'd0, cfg_valid}, 64'd0);
        @(negedge clk);
        chk("R8 valid", {63'd0, cfg_valid}, 64'd1);
        check_outs("run");
    endtask

    task automatic load(logic [7:0] s, logic [7:0] r, logic [47:0] m, logic [7:0] fm);
        mem[0] = s; mem[1] = r;
        for (int i = 0; i < 6; i++) mem[2+i] = m[(5-i)*8 +: 8];
        for (int i = 0; i < 8; i++) fmask[i] = fm[i];
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        load(8'h00, 8'h00, 48'h0, 8'h00);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 core_en", {63'd0, core_en}, 64'd0);
        chk("R10 rd_req", {63'd0, rd_req}, 64'd0);
        chk("R10 valid", {63'd0, cfg_valid}, 64'd0);
        chk("R10 outputs", {15'd0, speed_sel, ram_kb, station_addr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 stray done in idle
        inj_done = 1'b1; inj_data = 8'hA5;
        @(negedge clk); inj_done = 1'b0;
        @(negedge clk);
        chk("R9 idle stray", {15'd0, speed_sel, ram_kb, station_addr}, 64'd0);
        chk("R9 idle state", {62'd0, core_en, rd_req}, 64'd0);

        // directed: 16 Mbps, minimal RAM
        load(8'h00, 8'h01, 48'h0200_1122_3344, 8'h00);
        run_cfg(0, 1'b0);
        // directed: speed 1, RAM 255
        load(8'h01, 8'hFF, 48'hFFEE_DDCC_BBAA, 8'h00);
        run_cfg(2, 1'b0);
        // R9 stray done after valid
        inj_done = 1'b1; inj_data = 8'h00;
        @(negedge clk); inj_done = 1'b0;
        @(negedge clk);
        chk("R9 valid held", {63'd0, cfg_valid}, 64'd1);
        check_outs("R9 stray");
        // R7 all reads fail
        load(8'h00, 8'h00, 48'h0, 8'hFF);
        run_cfg(1, 1'b0);
        // R8 start during loading ignored
        load(8'h00, 8'h10, 48'h0A0B_0C0D_0E0F, 8'h00);
        run_cfg(3, 1'b1);
        // random
        for (int t = 0; t < 30; t++) begin
            logic [47:0] m;
            m = {$urandom, $urandom};
            load(($urandom % 3 == 0) ? 8'h00 : 8'($urandom), 8'($urandom), m,
                 ($urandom % 4 == 0) ? 8'($urandom) : 8'h00);
            run_cfg(int'($urandom % 5), ($urandom % 4) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule